// File: doc/BRIEF.md
# Carrier Interrupt Decimation Counter

This block sits beside a triangular-carrier counter in a motor-control timer. Each time the carrier counter runs out, it sends a one-cycle underflow strobe. The block counts these strobes and raises an interrupt request once a programmed number of them has been seen. Software can then service the PWM update at a lower rate than the carrier itself.

The carrier alternates between two reload registers, and a reload-select signal shows which one is active. With the polarity filter switched on, the block counts only the strobes whose reload-select level matches a chosen polarity. The interrupt is then tied to one half of the triangle. Two registers configure the block through a small write port: a control register and a count register.

Top module: `carrier_irq_decim`

## Requirements
- R1: After reset the request output is low, including while reset is held with underflow strobes present. The count is 1 and the filter is off, so the first underflow after reset raises a request.
- R2: With the filter off (control bit 1 = 0), every underflow strobe counts. The request fires on the N-th strobe, where N is the programmed count.
- R3: With the filter on (control bit 1 = 1), only strobes whose `reload_sel_i` equals the polarity (control bit 0) count. Other strobes neither fire nor advance the count.
- R4: With the filter on and a count of 1, a reload-select level that alternates on each underflow gives a request on every other underflow, always on the same level.
- R5: After a request, counting restarts from the programmed value, so the next request needs N more counted strobes.
- R6: The request is combinational with the qualifying strobe. It is high in the same clock cycle as the strobe and never in any other cycle, so back-to-back strobes with a count of 1 give back-to-back requests.
- R7: A programmed count of zero behaves exactly like a count of 1.
- R8: A write to the count register (address 1) discards partial progress. Counting restarts from the new value, with zero taken as 1.
- R9: When a count write and a qualifying strobe fall in the same cycle, the request in that cycle is decided by the count already in progress. The counter then restarts from the written value.
- R10: A write to the control register (address 0) changes only the filter and the polarity. It does not disturb the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| uf_i | input | 1 | One-cycle carrier underflow strobe |
| reload_sel_i | input | 1 | Level that shows which alternating reload register is active |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control (bit 0 polarity, bit 1 filter enable), 1: count |
| wr_data_i | input | CNT_W | Write data |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
Two things can land in the same clock cycle: a count-register write and a qualifying underflow. The bench steers the counter to its final step and then issues the write together with the strobe. It expects a request in that cycle and a restart from the written value. It repeats the collision at a mid-count step, where no request may appear and the new value must still take effect. A behavioural model predicts the request on every clock, and the bench compares each prediction against the output.

// File: rtl/cid_pkg.sv
package cid_pkg;
  // Register select on the write port
  typedef enum logic {
    CID_ADDR_CTRL  = 1'b0,
    CID_ADDR_COUNT = 1'b1
  } cid_addr_e;

  // Field positions inside the control register
  localparam int unsigned CID_POL_BIT  = 0;
  localparam int unsigned CID_FILT_BIT = 1;

  typedef struct packed {
    logic filt_en;
    logic pol;
  } cid_ctrl_t;
endpackage

// File: rtl/cid_rst_sync.sv
module cid_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cid_cfg_regs.sv
module cid_cfg_regs
  import cid_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output cid_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] reload_val_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cid_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] prog_q, prog_d;
  logic             ctrl_we, count_we;

  always_comb begin
    ctrl_we  = wr_en_i && (cid_addr_e'(wr_addr_i) == CID_ADDR_CTRL);
    count_we = wr_en_i && (cid_addr_e'(wr_addr_i) == CID_ADDR_COUNT);
    ctrl_d   = ctrl_q;
    prog_d   = prog_q;
    if (ctrl_we) begin
      ctrl_d.pol     = wr_data_i[CID_POL_BIT];
      ctrl_d.filt_en = wr_data_i[CID_FILT_BIT];
    end
    if (count_we) prog_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prog_q <= ONE;
    end else begin
      if (ctrl_we)  ctrl_q <= ctrl_d;
      if (count_we) prog_q <= prog_d;
    end
  end

  // Zero is clamped to one on both the reload and the restart path
  assign ctrl_o       = ctrl_q;
  assign reload_val_o = (prog_q == '0) ? ONE : prog_q;
  assign load_o       = count_we;
  assign load_val_o   = (wr_data_i == '0) ? ONE : wr_data_i;

  // R7
  reload_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_val_o != '0);
endmodule

// File: rtl/cid_qualifier.sv
module cid_qualifier
  import cid_pkg::*;
(
  input  logic      uf_i,
  input  logic      reload_sel_i,
  input  cid_ctrl_t ctrl_i,
  output logic      qual_o
);
  always_comb begin
    if (ctrl_i.filt_en) qual_o = uf_i && (reload_sel_i == ctrl_i.pol);
    else                qual_o = uf_i;
  end
endmodule

// File: rtl/cid_down_counter.sv
module cid_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last, cnt_en;

  always_comb begin
    last   = (cnt_q == ONE);
    cnt_en = load_i || qual_i;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (qual_i) cnt_d = last ? reload_val_i : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign irq_o = rst_n && qual_i && last;

  // R5
  reload_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !load_i) |=> (cnt_q == $past(reload_val_i)));
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_i && !load_i) |=> $stable(cnt_q));
  // R8
  restart_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R7
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
endmodule

// File: rtl/carrier_irq_decim.sv
module carrier_irq_decim
  import cid_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_i,
  input  logic             reload_sel_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_o
);
  logic             rst_n_int;
  cid_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload_val, load_val;
  logic             load, qual;

  cid_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  cid_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_int), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl), .reload_val_o(reload_val),
    .load_o(load), .load_val_o(load_val));

  cid_qualifier u_qual (
    .uf_i(uf_i), .reload_sel_i(reload_sel_i), .ctrl_i(ctrl), .qual_o(qual));

  cid_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .qual_i(qual), .load_i(load),
    .load_val_i(load_val), .reload_val_i(reload_val), .irq_o(irq_o));

  // R6
  irq_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o |-> uf_i);
  // R3
  filter_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl.filt_en && (reload_sel_i != ctrl.pol)) |-> !irq_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> !irq_o);
endmodule

// File: tb/carrier_irq_decim_test.sv
`timescale 1ns/1ps
module carrier_irq_decim_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         uf, sel, we, addr;
  logic [W-1:0] data;
  logic         irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // behavioural reference state
  int  m_rem, m_prog;
  bit  m_filt, m_pol;

  always #2.5 clk = ~clk;

  carrier_irq_decim #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .uf_i(uf), .reload_sel_i(sel),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data), .irq_o(irq));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, compare, then advance the model
  task automatic step(input bit u, input bit s, input bit w, input bit a,
                      input int d, input string tag);
    bit q, e;
    int eff;
    @(negedge clk);
    uf = u; sel = s; we = w; addr = a; data = W'(d);
    #1;
    q = u && (!m_filt || (s == m_pol));
    e = q && (m_rem == 1);
    check(irq, e, tag);
    if (w && a) begin
      m_prog = d;
      m_rem  = (d == 0) ? 1 : d;
    end else if (q) begin
      m_rem = (m_rem == 1) ? ((m_prog == 0) ? 1 : m_prog) : m_rem - 1;
    end
    if (w && !a) begin
      m_filt = d[1];
      m_pol  = d[0];
    end
  endtask

  task automatic strobe(input bit s, input string tag);
    step(1, s, 0, 0, 0, tag);
    step(0, s, 0, 0, 0, tag);
  endtask

  task automatic wr(input bit a, input int d, input string tag);
    step(0, 0, 1, a, d, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uf = 1'b0; sel = 1'b0; we = 1'b0; addr = 1'b0; data = '0;
    m_rem = 1; m_prog = 1; m_filt = 0; m_pol = 0;
    // R1: quiet while reset is held, even with strobes present
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); uf = 1'b1; #1; check(irq, 1'b0, "R1");
    end
    @(negedge clk); uf = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R1");
    // R1: default count of one fires on the first strobe
    strobe(0, "R1");
    strobe(1, "R2");
    // R2 / R5: count of 3, filter off, seven strobes
    wr(1, 3, "R8");
    for (int i = 0; i < 7; i++) begin
      strobe(i[0], "R2");
      step(0, 0, 0, 0, 0, "R5");
    end
    // R7: zero behaves like one
    wr(1, 0, "R7");
    for (int i = 0; i < 4; i++) strobe(i[0], "R7");
    // R6: back-to-back strobes with count one
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R3 / R4: filter on, polarity 1, count 1, alternating level
    wr(0, 3, "R10");
    wr(1, 1, "R4");
    for (int i = 0; i < 8; i++) strobe(i[0], "R4");
    // R4: polarity 0
    wr(0, 2, "R4");
    for (int i = 0; i < 8; i++) strobe(i[0], "R4");
    // R3: count 3, irregular levels
    wr(1, 3, "R3");
    strobe(1, "R3"); strobe(1, "R3"); strobe(0, "R3"); strobe(1, "R3");
    strobe(0, "R3"); strobe(0, "R3"); strobe(1, "R3"); strobe(0, "R3");
    // R8: partial progress discarded
    wr(0, 0, "R10");
    wr(1, 5, "R8");
    strobe(0, "R8"); strobe(0, "R8");
    wr(1, 2, "R8");
    for (int i = 0; i < 4; i++) strobe(0, "R8");
    // R10: control write in mid count leaves progress untouched
    wr(1, 4, "R10");
    strobe(0, "R10"); strobe(0, "R10");
    wr(0, 0, "R10");
    strobe(0, "R10"); strobe(0, "R10"); strobe(0, "R10");
    // R9: write collides with the final qualifying strobe
    wr(1, 2, "R9");
    strobe(0, "R9");
    step(1, 0, 1, 1, 3, "R9");
    for (int i = 0; i < 4; i++) strobe(0, "R9");
    // R9: write collides with a mid-count strobe
    step(1, 0, 1, 1, 2, "R9");
    for (int i = 0; i < 3; i++) strobe(0, "R9");
    // R9: collision with a zero write
    wr(1, 1, "R9");
    step(1, 0, 1, 1, 0, "R9");
    strobe(0, "R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule